// File: doc/BRIEF.md
# Receive Control Character Matcher

This block sits behind a serial receiver and classifies each incoming character against a small programmable table of control characters. Each table word holds a character value, a flag that marks the end of the usable table and a flag that selects rejection. One shared mask register decides which bit positions take part in the comparison. Each character arrives with a one-cycle valid strobe. One clock later the block issues one of three actions: it writes the character to the receive buffer as plain data, it writes it and asks for the buffer to be closed, or it withholds it from the buffer and latches it into a held-character register.

An interrupt pulse goes out on any table hit, gated by a single enable bit. The table words, the mask and the enable are loaded through a write-only register port. Word addresses 0 to N_ENT-1 select table entries, address N_ENT selects the mask and address N_ENT+1 selects the control word.

Top module: `ctlchar_matcher`

## Requirements
- R1: After reset all output pulses are low, `held_char` is zero, every table entry is marked as end of table, the mask compares all bits and the interrupt enable is off, so any character passes as plain data.
- R2: A valid character that matches no live entry gives `buf_we`=1 with `buf_data` equal to the character, `buf_close`=0 and `irq`=0.
- R3: A hit on an entry whose reject flag (bit 14) is 0 gives `buf_we`=1 and `buf_close`=1, with the character on `buf_data`.
- R4: A hit on an entry whose reject flag is 1 gives `buf_we`=0 and `buf_close`=0, and loads the character into `held_char`.
- R5: An entry whose end flag (bit 15) is 1 takes no part in matching, and neither does any entry with a higher index.
- R6: When the end flag is 0 in all entries, every entry takes part in matching.
- R7: Mask bit k (k in 7:0) set to 0 excludes character bit k from the comparison. Set to 1, it compares bit k normally. The character value is held in entry bits 7:0.
- R8: Mask register bits 15:8, which include the two top bits that software is expected to set, have no effect on matching.
- R9: When several live entries match, the lowest-indexed one decides the action.
- R10: `irq` pulses on a table hit only when the enable bit (control word bit 0) is 1.
- R11: `held_char` changes only on a reject hit and otherwise keeps its value.
- R12: Outputs respond in the cycle after the valid strobe and are single-cycle pulses: with no strobe in the previous cycle, `buf_we`, `buf_close` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Word address: entries, then mask, then control |
| cfg_wdata | input | 16 | Configuration write data |
| rx_valid | input | 1 | Incoming character strobe |
| rx_char | input | 8 | Incoming character, right-aligned |
| buf_we | output | 1 | Write pulse toward the receive buffer |
| buf_data | output | 8 | Character to write to the buffer |
| buf_close | output | 1 | Close-buffer request pulse |
| irq | output | 1 | Interrupt pulse on a table hit |
| held_char | output | 8 | Last rejected control character |

## Verification
The bench aims at the table terminator. A terminator at index 0 empties the table, one in the middle hides the later entries, and a table with no terminator must use all eight. A design that scans past the terminator or stops one entry short would close buffers on data characters or miss real control codes. Duplicate entries with different reject flags test priority: a wrong priority closes the buffer where the character should have been diverted. Masks with cleared bits and with arbitrary upper bits test that only the low eight bits gate the compare. A held register that tracks every character, or an interrupt that ignores the enable, shows up in checks made after non-reject traffic and with the enable off.

// File: rtl/ctlchar_pkg.sv
// Shared definitions for the control character matcher.
// Assumes 16-bit table words with the flags in the two top bits.
package ctlchar_pkg;
    localparam int ENTRY_W = 16;
    localparam int END_BIT = 15;
    localparam int REJ_BIT = 14;

    // Decision taken for one received character
    typedef enum logic [1:0] {
        ACT_DATA   = 2'd0,
        ACT_CLOSE  = 2'd1,
        ACT_REJECT = 2'd2
    } act_e;
endpackage

// File: rtl/ctlchar_table.sv
// Holds the control character table, the compare mask and the interrupt
// enable, and works out which entries are live (before the first end flag).
// Assumes word addresses: entries 0..N_ENT-1, mask N_ENT, control N_ENT+1.
module ctlchar_table
    import ctlchar_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int N_ENT  = 8,
    parameter int ADDR_W = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [ADDR_W-1:0]              cfg_addr,
    input  logic [ENTRY_W-1:0]             cfg_wdata,
    output logic [N_ENT-1:0][CHAR_W-1:0]   ent_char,
    output logic [N_ENT-1:0]               ent_rej,
    output logic [N_ENT-1:0]               ent_live,
    output logic [CHAR_W-1:0]              cmp_mask,
    output logic                           irq_en
);
    localparam int MASK_ADDR = N_ENT;
    localparam int CTRL_ADDR = N_ENT + 1;

    logic [N_ENT-1:0] end_q;
    logic             unused_cfg_bits;

    assign unused_cfg_bits = ^cfg_wdata[ENTRY_W-3:CHAR_W];

    genvar gi;
    generate
        for (gi = 0; gi < N_ENT; gi++) begin : g_ent
            // Store one table word: end flag, reject flag, character value
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    end_q[gi]    <= 1'b1;
                    ent_rej[gi]  <= 1'b0;
                    ent_char[gi] <= '0;
                end else if (cfg_we && cfg_addr == ADDR_W'(gi)) begin
                    end_q[gi]    <= cfg_wdata[END_BIT];
                    ent_rej[gi]  <= cfg_wdata[REJ_BIT];
                    ent_char[gi] <= cfg_wdata[CHAR_W-1:0];
                end
            end

            // An entry is live only if it and all lower entries lack the end flag
            if (gi == 0) begin : g_first
                assign ent_live[gi] = ~end_q[gi];
            end else begin : g_rest
                assign ent_live[gi] = ent_live[gi-1] & ~end_q[gi];
            end
        end
    endgenerate

    // Store the compare mask (only the character-width low bits are kept)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_mask <= '1;
        end else if (cfg_we && cfg_addr == ADDR_W'(MASK_ADDR)) begin
            cmp_mask <= cfg_wdata[CHAR_W-1:0];
        end
    end

    // Store the interrupt enable bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en <= 1'b0;
        end else if (cfg_we && cfg_addr == ADDR_W'(CTRL_ADDR)) begin
            irq_en <= cfg_wdata[0];
        end
    end
endmodule

// File: rtl/ctlchar_compare.sv
// Compares one character against every live table entry through the shared
// mask and picks the lowest-indexed hit. Purely combinational.
// Assumes short characters are right-aligned with zero upper bits.
module ctlchar_compare #(
    parameter int CHAR_W = 8,
    parameter int N_ENT  = 8
) (
    input  logic [CHAR_W-1:0]              rx_char,
    input  logic [N_ENT-1:0][CHAR_W-1:0]   ent_char,
    input  logic [N_ENT-1:0]               ent_rej,
    input  logic [N_ENT-1:0]               ent_live,
    input  logic [CHAR_W-1:0]              cmp_mask,
    output logic                           hit,
    output logic                           hit_rej
);
    logic [N_ENT-1:0] ent_match;

    genvar gi;
    generate
        for (gi = 0; gi < N_ENT; gi++) begin : g_cmp
            assign ent_match[gi] = ent_live[gi] &
                (((rx_char ^ ent_char[gi]) & cmp_mask) == '0);
        end
    endgenerate

    // Priority pick: scan downward so the lowest matching index wins
    always_comb begin
        hit     = 1'b0;
        hit_rej = 1'b0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (ent_match[i]) begin
                hit     = 1'b1;
                hit_rej = ent_rej[i];
            end
        end
    end
endmodule

// File: rtl/ctlchar_action.sv
// Turns the compare result into registered one-cycle output pulses and
// keeps the held register for rejected characters.
// Assumes rx_valid is a single-cycle strobe per character.
module ctlchar_action
    import ctlchar_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              hit,
    input  logic              hit_rej,
    input  logic              irq_en,
    output logic              buf_we,
    output logic [CHAR_W-1:0] buf_data,
    output logic              buf_close,
    output logic              irq,
    output logic [CHAR_W-1:0] held_char
);
    act_e act;

    // Classify the current character
    always_comb begin
        if (!hit)         act = ACT_DATA;
        else if (hit_rej) act = ACT_REJECT;
        else              act = ACT_CLOSE;
    end

    // Register the pulses for one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_we    <= 1'b0;
            buf_close <= 1'b0;
            irq       <= 1'b0;
        end else begin
            buf_we    <= rx_valid && (act != ACT_REJECT);
            buf_close <= rx_valid && (act == ACT_CLOSE);
            irq       <= rx_valid && (act != ACT_DATA) && irq_en;
        end
    end

    // Capture the character offered to the buffer
    always_ff @(posedge clk) begin
        if (!rst_n)        buf_data <= '0;
        else if (rx_valid) buf_data <= rx_char;
    end

    // Keep the last rejected control character
    always_ff @(posedge clk) begin
        if (!rst_n)                                held_char <= '0;
        else if (rx_valid && act == ACT_REJECT)    held_char <= rx_char;
    end
endmodule

// File: rtl/ctlchar_matcher.sv
// Top of the control character matcher: table storage, compare and
// action stages. Assumes a write-only configuration port.
module ctlchar_matcher
    import ctlchar_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int N_ENT  = 8,
    parameter int ADDR_W = $clog2(N_ENT + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [15:0]       cfg_wdata,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    output logic              buf_we,
    output logic [CHAR_W-1:0] buf_data,
    output logic              buf_close,
    output logic              irq,
    output logic [CHAR_W-1:0] held_char
);
    logic [N_ENT-1:0][CHAR_W-1:0] ent_char_w;
    logic [N_ENT-1:0]             ent_rej_w;
    logic [N_ENT-1:0]             ent_live_w;
    logic [CHAR_W-1:0]            cmp_mask_w;
    logic                         irq_en_w;
    logic                         hit_w;
    logic                         hit_rej_w;

    ctlchar_table #(.CHAR_W(CHAR_W), .N_ENT(N_ENT), .ADDR_W(ADDR_W)) u_table (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ent_char(ent_char_w), .ent_rej(ent_rej_w),
        .ent_live(ent_live_w), .cmp_mask(cmp_mask_w), .irq_en(irq_en_w)
    );

    ctlchar_compare #(.CHAR_W(CHAR_W), .N_ENT(N_ENT)) u_cmp (
        .rx_char(rx_char), .ent_char(ent_char_w), .ent_rej(ent_rej_w),
        .ent_live(ent_live_w), .cmp_mask(cmp_mask_w),
        .hit(hit_w), .hit_rej(hit_rej_w)
    );

    ctlchar_action #(.CHAR_W(CHAR_W)) u_act (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
        .hit(hit_w), .hit_rej(hit_rej_w), .irq_en(irq_en_w),
        .buf_we(buf_we), .buf_data(buf_data), .buf_close(buf_close),
        .irq(irq), .held_char(held_char)
    );
endmodule

// File: rtl/ctlchar_matcher_chk.sv
// Protocol checks for the control character matcher, bound to the top.
// Assumes synchronous active-low reset.
module ctlchar_matcher_chk #(
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              buf_we,
    input logic              buf_close,
    input logic              irq,
    input logic              irq_en,
    input logic [CHAR_W-1:0] held_char
);
    assert_close_has_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        buf_close |-> buf_we);

    assert_reject_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !buf_close) |-> !buf_we);

    assert_plain_no_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we && !buf_close) |-> !irq);

    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(irq_en));

    assert_held_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(held_char));

    assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> (!buf_we && !buf_close && !irq));
endmodule

bind ctlchar_matcher ctlchar_matcher_chk #(.CHAR_W(CHAR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .buf_we(buf_we),
    .buf_close(buf_close), .irq(irq), .irq_en(irq_en_w), .held_char(held_char)
);

// File: tb/ctlchar_matcher_test.sv
module ctlchar_matcher_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_char = '0;
    logic        buf_we, buf_close, irq;
    logic [7:0]  buf_data, held_char;

    int total = 0;
    int bad = 0;

    bit [15:0] m_ent [8];
    bit [7:0]  m_mask;
    bit        m_ien;
    bit [7:0]  m_held;

    ctlchar_matcher uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_char(rx_char),
        .buf_we(buf_we), .buf_data(buf_data), .buf_close(buf_close),
        .irq(irq), .held_char(held_char)
    );

    always #5 clk = ~clk;

    // Model: index of the lowest live matching entry, or -1
    function automatic int first_hit(bit [7:0] c);
        for (int i = 0; i < 8; i++) begin
            if (m_ent[i][15]) return -1;
            if (((c ^ m_ent[i][7:0]) & m_mask) == 8'h00) return i;
        end
        return -1;
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cfg_write(int addr, bit [15:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        if (addr < 8) m_ent[addr] = data;
        else if (addr == 8) m_mask = data[7:0];
        else if (addr == 9) m_ien = data[0];
    endtask

    task automatic send(bit [7:0] c, string tag_in);
        int    h;
        bit    rej, e_we, e_close, e_irq;
        string tag;
        h = first_hit(c);
        rej = (h >= 0) && m_ent[h][14];
        e_we = !rej;
        e_close = (h >= 0) && !rej;
        e_irq = (h >= 0) && m_ien;
        if (rej) m_held = c;
        if (tag_in != "") tag = tag_in;
        else if (h < 0) tag = "R2";
        else if (rej) tag = "R4";
        else tag = "R3";
        @(negedge clk);
        rx_valid = 1'b1; rx_char = c;
        @(negedge clk);
        rx_valid = 1'b0;
        check({buf_we, buf_close, irq} == {e_we, e_close, e_irq}, tag,
              "we/close/irq", {buf_we, buf_close, irq}, {e_we, e_close, e_irq});
        if (e_we) check(buf_data == c, tag, "buf_data", buf_data, c);
        check(held_char == m_held, tag, "held_char", held_char, m_held);
        @(negedge clk);
        check({buf_we, buf_close, irq} == 3'b000, "R12", "pulse after idle",
              {buf_we, buf_close, irq}, 0);
    endtask

    task automatic clear_table();
        for (int i = 0; i < 8; i++) cfg_write(i, 16'h8000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 8; i++) m_ent[i] = 16'h8000;
        m_mask = 8'hFF; m_ien = 1'b0; m_held = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check({buf_we, buf_close, irq} == 3'b000, "R1", "pulses after reset",
              {buf_we, buf_close, irq}, 0);
        check(held_char == 8'h00, "R1", "held after reset", held_char, 0);
        send(8'h00, "R1");
        send(8'hFF, "R1");

        cfg_write(9, 16'h0001);
        // R5: terminator in the middle hides later entries
        cfg_write(0, 16'h0041);
        cfg_write(1, 16'h8042);
        cfg_write(2, 16'h0043);
        send(8'h41, "R3");
        send(8'h42, "R5");
        send(8'h43, "R5");
        // R5: terminator at index 0 empties the table
        cfg_write(0, 16'h8041);
        send(8'h41, "R5");

        // R6: all eight entries live
        for (int i = 0; i < 8; i++) cfg_write(i, 16'h0060 + 16'(i));
        for (int i = 0; i < 8; i++) send(8'h60 + 8'(i), "R6");
        send(8'h68, "R2");

        // R9: lowest index wins between duplicates
        cfg_write(0, 16'h4055);
        cfg_write(1, 16'h0055);
        send(8'h55, "R9");
        cfg_write(0, 16'h0055);
        cfg_write(1, 16'h4055);
        send(8'h55, "R9");

        // R7: cleared mask bits are ignored
        clear_table();
        cfg_write(0, 16'h0030);
        cfg_write(8, 16'h00F0);
        send(8'h35, "R7");
        send(8'h45, "R7");
        // R8: upper mask bits make no difference
        cfg_write(8, 16'hC0F0);
        send(8'h3A, "R8");
        send(8'h50, "R8");
        cfg_write(8, 16'h3FFF);
        send(8'h30, "R8");
        send(8'h31, "R8");

        // R4 and R11: reject then other traffic keeps held value
        cfg_write(8, 16'hC0FF);
        cfg_write(1, 16'h4077);
        send(8'h77, "R4");
        send(8'h30, "R11");
        send(8'h12, "R11");
        // R10: enable off suppresses irq
        cfg_write(9, 16'h0000);
        send(8'h30, "R10");
        send(8'h77, "R10");
        cfg_write(9, 16'h0001);

        // Random configurations and traffic
        for (int round = 0; round < 40; round++) begin
            int used;
            used = $urandom_range(0, 8);
            for (int i = 0; i < 8; i++) begin
                bit [15:0] w;
                w = 16'($urandom) & 16'h40FF;
                if (i == used) w[15] = 1'b1;
                else if (i > used) w[15] = 1'($urandom);
                cfg_write(i, w);
            end
            if ($urandom_range(0, 1) == 1) cfg_write(8, 16'($urandom) | 16'h00FF);
            else cfg_write(8, 16'($urandom));
            cfg_write(9, 16'($urandom_range(0, 1)));
            for (int k = 0; k < 8; k++) begin
                bit [7:0] c;
                if ($urandom_range(0, 1) == 1) begin
                    int pick;
                    pick = $urandom_range(0, 7);
                    c = m_ent[pick][7:0] ^ (8'($urandom) & ~m_mask);
                end else begin
                    c = 8'($urandom);
                end
                send(c, "");
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule